// File: doc/BRIEF.md
# Parallel Bus Chip-Select Timing Sequencer

This block runs single read or write cycles on an asynchronous parallel bus for one chip-select region, such as a register window of a storage card or disk-style device. A host pulses a request carrying address, write data, direction and a width flag for 8 or 16 bits. If the region is enabled and the sequencer is idle, the request is latched. The block then walks through five timed phases in a fixed order: an address lead with chip-enable still high, a delay from chip-enable to the strobe, the active strobe, a hold before chip-enable is released, and a pause before the next cycle.

Each phase lasts a programmed count plus one, measured in ticks. One tick is a group of base clocks chosen by a 2-bit prescaler code. In wait mode the strobe phase is stretched for as long as the device holds its ready input low. A programmed tail then keeps the strobe, and any write data, driven after ready returns. A read captures the bus data on the clock edge where output-enable is released. The block pulses done for one cycle with the read data.

Top module: `pbus_cycle_seq`

## Requirements
- R1: During and after reset, with no request, cfCeN, cfOeN and cfWeN are high (all strobes active low), cfDoutEn, busy and done are low.
- R2: The prescaler code cfgMult selects the tick length in clocks: 0 gives 4, 1 gives 1, 2 gives 2, 3 gives 8. A phase field value N lasts (N+1) ticks.
- R3: After acceptance, cfCeN stays high for (tAdr+1) ticks. Then cfCeN goes low and the strobe starts (tCe+1) ticks later. cfCeN stays low for (tHold+1) ticks after the strobe ends, where tHold is tRdHold for reads and tWrHold for writes.
- R4: busy is high from the clock after acceptance until the pause phase of (tPause+1) ticks ends. done is high for exactly one clock, in the first clock with busy low. cfCeN is never low while busy is low.
- R5: A read pulses only cfOeN, for (tOe+1) ticks. A write pulses only cfWeN, for (tWe+1) ticks. The two strobes are never low together.
- R6: With cfgWaitMode set, the strobe phase lasts until both its count has expired and cfReady is high. The strobe then stays low for a further (tWait+1) ticks before the hold phase begins.
- R7: With cfgWaitMode clear, cfReady has no effect on any phase length.
- R8: A read returns, on rdData, the value of cfDin at the clock edge where cfOeN rises. Later changes of cfDin do not alter rdData.
- R9: An 8-bit cycle drives only the low byte: the upper byte of cfDout is zero. An 8-bit read returns zero in the upper byte of rdData.
- R10: While cfgEnable is low, requests are ignored: no busy, no done, no bus activity.
- R11: A request that arrives while busy is ignored and does not change the running cycle.
- R12: Whenever cfCeN is low, cfAddr equals the accepted address. Whenever cfWeN is low, cfDoutEn is high and cfDout holds the accepted write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Host request strobe, one clock |
| reqWrite | input | 1 | 1 = write cycle, 0 = read cycle |
| reqWide | input | 1 | 1 = 16-bit cycle, 0 = 8-bit cycle |
| reqAddr | input | ADDR_W | Register address |
| reqWdata | input | DATA_W | Write data |
| cfgEnable | input | 1 | Region enable |
| cfgMult | input | 2 | Tick prescaler code |
| cfgWaitMode | input | 1 | Enable ready-based strobe stretching |
| tAdr | input | FIELD_W | Address lead count |
| tCe | input | FIELD_W | Chip-enable to strobe count |
| tOe | input | FIELD_W | Read strobe count |
| tWe | input | FIELD_W | Write strobe count |
| tWait | input | FIELD_W | Strobe tail after ready returns |
| tRdHold | input | FIELD_W | Hold after read strobe |
| tWrHold | input | FIELD_W | Hold after write strobe |
| tPause | input | FIELD_W | Pause after chip-enable release |
| cfReady | input | 1 | Device ready, low stretches the strobe |
| cfDin | input | DATA_W | Read data from the bus |
| cfCeN | output | 1 | Chip enable, active low |
| cfOeN | output | 1 | Output enable, active low |
| cfWeN | output | 1 | Write enable, active low |
| cfAddr | output | ADDR_W | Bus address |
| cfDout | output | DATA_W | Bus write data |
| cfDoutEn | output | 1 | Write data drive enable |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | One-clock completion pulse |
| rdData | output | DATA_W | Captured read data |

## Verification
The assertions assume that the timing fields, prescaler code, wait-mode bit and region enable are held constant from acceptance until done. The phase length checks are only meaningful under that condition. The stimulus changes configuration only between cycles, after done has been seen. cfReady is assumed to move only at clock edges the bench controls. The bench drives it low at the start of each cycle and raises it after a chosen number of strobe clocks. Random fields are kept small so that long prescalers still finish quickly.

// File: rtl/pbus_seq_pkg.sv
package pbus_seq_pkg;

  localparam int PRE_W = 3;

  typedef enum logic [2:0] {
    PH_IDLE, PH_ADR, PH_CE, PH_STROBE, PH_WAIT, PH_HOLD, PH_PAUSE
  } phase_t;

  typedef struct packed {
    logic accept;
    logic isWrite;
    logic ceOn;
    logic strobeOn;
    logic drive;
    logic capture;
  } bus_ctl_t;

  function automatic logic [3:0] multCycles(input logic [1:0] code);
    case (code)
      2'd0:    return 4'd4;
      2'd1:    return 4'd1;
      2'd2:    return 4'd2;
      default: return 4'd8;
    endcase
  endfunction

endpackage

// File: rtl/pbus_seq_ctrl.sv
module pbus_seq_ctrl
  import pbus_seq_pkg::*;
#(
  parameter int FIELD_W = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic               reqWrite,
  input  logic               cfgEnable,
  input  logic [1:0]         cfgMult,
  input  logic               cfgWaitMode,
  input  logic [FIELD_W-1:0] tAdr,
  input  logic [FIELD_W-1:0] tCe,
  input  logic [FIELD_W-1:0] tOe,
  input  logic [FIELD_W-1:0] tWe,
  input  logic [FIELD_W-1:0] tWait,
  input  logic [FIELD_W-1:0] tRdHold,
  input  logic [FIELD_W-1:0] tWrHold,
  input  logic [FIELD_W-1:0] tPause,
  input  logic               cfReady,
  output bus_ctl_t           busCtl,
  output logic               busy,
  output logic               done
);

  phase_t             phase, nextPhase;
  logic [PRE_W-1:0]   preCnt, preLoad;
  logic [FIELD_W-1:0] phCnt, phLoad;
  logic               wrLat;
  logic               tickEnd, phaseEnd, accept;
  logic [3:0]         multVal;

  assign multVal  = multCycles(cfgMult);
  assign preLoad  = PRE_W'(multVal - 4'd1);
  assign tickEnd  = (preCnt == '0);
  assign phaseEnd = tickEnd && (phCnt == '0);
  assign accept   = (phase == PH_IDLE) && reqValid && cfgEnable;

  always_comb begin
    nextPhase = phase;
    case (phase)
      PH_IDLE:   if (accept) nextPhase = PH_ADR;
      PH_ADR:    if (phaseEnd) nextPhase = PH_CE;
      PH_CE:     if (phaseEnd) nextPhase = PH_STROBE;
      PH_STROBE: if (phaseEnd) begin
                   if (!cfgWaitMode)  nextPhase = PH_HOLD;
                   else if (cfReady)  nextPhase = PH_WAIT;
                 end
      PH_WAIT:   if (phaseEnd) nextPhase = PH_HOLD;
      PH_HOLD:   if (phaseEnd) nextPhase = PH_PAUSE;
      PH_PAUSE:  if (phaseEnd) nextPhase = PH_IDLE;
      default:   nextPhase = PH_IDLE;
    endcase
  end

  always_comb begin
    case (nextPhase)
      PH_ADR:    phLoad = tAdr;
      PH_CE:     phLoad = tCe;
      PH_STROBE: phLoad = wrLat ? tWe : tOe;
      PH_WAIT:   phLoad = tWait;
      PH_HOLD:   phLoad = wrLat ? tWrHold : tRdHold;
      PH_PAUSE:  phLoad = tPause;
      default:   phLoad = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= PH_IDLE;
      preCnt <= '0;
      phCnt  <= '0;
      wrLat  <= 1'b0;
      done   <= 1'b0;
    end else begin
      phase <= nextPhase;
      done  <= (phase == PH_PAUSE) && (nextPhase == PH_IDLE);
      if (accept) wrLat <= reqWrite;
      if (nextPhase != phase) begin
        preCnt <= preLoad;
        phCnt  <= phLoad;
      end else if (phase != PH_IDLE) begin
        if (!tickEnd) begin
          preCnt <= preCnt - 1'b1;
        end else if (phCnt != '0) begin
          phCnt  <= phCnt - 1'b1;
          preCnt <= preLoad;
        end
      end
    end
  end

  assign busy            = (phase != PH_IDLE);
  assign busCtl.accept   = accept;
  assign busCtl.isWrite  = wrLat;
  assign busCtl.ceOn     = (phase == PH_CE) || (phase == PH_STROBE) ||
                           (phase == PH_WAIT) || (phase == PH_HOLD);
  assign busCtl.strobeOn = (phase == PH_STROBE) || (phase == PH_WAIT);
  assign busCtl.drive    = wrLat && (phase != PH_IDLE) && (phase != PH_PAUSE);
  assign busCtl.capture  = !wrLat && busCtl.strobeOn && (nextPhase == PH_HOLD);

  // R10: a request while the region is disabled starts nothing
  a_r10_disabled_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && reqValid && !cfgEnable) |=> !busy);

  // R11: the address phase is entered only from idle
  a_r11_no_restart: assert property (@(posedge clk) disable iff (!rstN)
    (phase != PH_IDLE && phase != PH_ADR) |=> (phase != PH_ADR));

  // R7: without wait mode an expired strobe always moves to hold
  a_r7_no_stretch: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgWaitMode && phase == PH_STROBE && phaseEnd) |=> (phase == PH_HOLD));

  // R4: done pulses only once the sequencer is idle again
  a_r4_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

endmodule

// File: rtl/pbus_seq_dpath.sv
module pbus_seq_dpath
  import pbus_seq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  bus_ctl_t          busCtl,
  input  logic              reqWide,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] cfDin,
  output logic              cfCeN,
  output logic              cfOeN,
  output logic              cfWeN,
  output logic [ADDR_W-1:0] cfAddr,
  output logic [DATA_W-1:0] cfDout,
  output logic              cfDoutEn,
  output logic [DATA_W-1:0] rdData
);

  localparam int LOW_W = DATA_W / 2;

  logic              wideLat;
  logic [ADDR_W-1:0] addrLat;
  logic [DATA_W-1:0] wdataLat;
  logic [DATA_W-1:0] dinMasked;

  assign dinMasked = wideLat ? cfDin : {{(DATA_W-LOW_W){1'b0}}, cfDin[LOW_W-1:0]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wideLat  <= 1'b0;
      addrLat  <= '0;
      wdataLat <= '0;
      rdData   <= '0;
    end else begin
      if (busCtl.accept) begin
        wideLat  <= reqWide;
        addrLat  <= reqAddr;
        wdataLat <= reqWide ? reqWdata
                            : {{(DATA_W-LOW_W){1'b0}}, reqWdata[LOW_W-1:0]};
      end
      if (busCtl.capture) rdData <= dinMasked;
    end
  end

  assign cfCeN    = !busCtl.ceOn;
  assign cfOeN    = !(busCtl.strobeOn && !busCtl.isWrite);
  assign cfWeN    = !(busCtl.strobeOn && busCtl.isWrite);
  assign cfAddr   = addrLat;
  assign cfDout   = wdataLat;
  assign cfDoutEn = busCtl.drive;

  // R5: the two strobes are never active together
  a_r5_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !(!cfOeN && !cfWeN));

  // R12: write data is driven for the whole write strobe
  a_r12_dout_driven: assert property (@(posedge clk) disable iff (!rstN)
    !cfWeN |-> cfDoutEn);

  // R8: read data is the bus value at the edge where output-enable rises
  a_r8_capture_edge: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cfOeN) |-> (rdData == ($past(wideLat) ? $past(cfDin)
                      : {{(DATA_W-LOW_W){1'b0}}, $past(cfDin[LOW_W-1:0])})));

endmodule

// File: rtl/pbus_cycle_seq.sv
module pbus_cycle_seq
  import pbus_seq_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 16,
  parameter int FIELD_W = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic               reqWrite,
  input  logic               reqWide,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [DATA_W-1:0]  reqWdata,
  input  logic               cfgEnable,
  input  logic [1:0]         cfgMult,
  input  logic               cfgWaitMode,
  input  logic [FIELD_W-1:0] tAdr,
  input  logic [FIELD_W-1:0] tCe,
  input  logic [FIELD_W-1:0] tOe,
  input  logic [FIELD_W-1:0] tWe,
  input  logic [FIELD_W-1:0] tWait,
  input  logic [FIELD_W-1:0] tRdHold,
  input  logic [FIELD_W-1:0] tWrHold,
  input  logic [FIELD_W-1:0] tPause,
  input  logic               cfReady,
  input  logic [DATA_W-1:0]  cfDin,
  output logic               cfCeN,
  output logic               cfOeN,
  output logic               cfWeN,
  output logic [ADDR_W-1:0]  cfAddr,
  output logic [DATA_W-1:0]  cfDout,
  output logic               cfDoutEn,
  output logic               busy,
  output logic               done,
  output logic [DATA_W-1:0]  rdData
);

  bus_ctl_t busCtl;

  pbus_seq_ctrl #(.FIELD_W(FIELD_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .cfgEnable(cfgEnable), .cfgMult(cfgMult), .cfgWaitMode(cfgWaitMode),
    .tAdr(tAdr), .tCe(tCe), .tOe(tOe), .tWe(tWe), .tWait(tWait),
    .tRdHold(tRdHold), .tWrHold(tWrHold), .tPause(tPause),
    .cfReady(cfReady), .busCtl(busCtl), .busy(busy), .done(done)
  );

  pbus_seq_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dpath_i (
    .clk(clk), .rstN(rstN), .busCtl(busCtl), .reqWide(reqWide),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .cfDin(cfDin),
    .cfCeN(cfCeN), .cfOeN(cfOeN), .cfWeN(cfWeN), .cfAddr(cfAddr),
    .cfDout(cfDout), .cfDoutEn(cfDoutEn), .rdData(rdData)
  );

  // R4: chip-enable is only active inside a busy cycle
  a_r4_ce_in_busy: assert property (@(posedge clk) disable iff (!rstN)
    !cfCeN |-> busy);

endmodule

// File: tb/pbus_cycle_seq_tb_top.sv
module pbus_cycle_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;
  localparam int FIELD_W = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0, reqWide = 1'b1;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [DATA_W-1:0] reqWdata = '0;
  logic cfgEnable = 1'b1;
  logic [1:0] cfgMult = 2'd1;
  logic cfgWaitMode = 1'b0;
  logic [FIELD_W-1:0] tAdr = '0, tCe = '0, tOe = '0, tWe = '0, tWait = '0;
  logic [FIELD_W-1:0] tRdHold = '0, tWrHold = '0, tPause = '0;
  logic cfReady = 1'b0;
  logic [DATA_W-1:0] cfDin = '0;
  logic cfCeN, cfOeN, cfWeN, cfDoutEn, busy, done;
  logic [ADDR_W-1:0] cfAddr;
  logic [DATA_W-1:0] cfDout, rdData;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pbus_cycle_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FIELD_W(FIELD_W)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqWide(reqWide), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .cfgEnable(cfgEnable), .cfgMult(cfgMult), .cfgWaitMode(cfgWaitMode),
    .tAdr(tAdr), .tCe(tCe), .tOe(tOe), .tWe(tWe), .tWait(tWait),
    .tRdHold(tRdHold), .tWrHold(tWrHold), .tPause(tPause),
    .cfReady(cfReady), .cfDin(cfDin), .cfCeN(cfCeN), .cfOeN(cfOeN),
    .cfWeN(cfWeN), .cfAddr(cfAddr), .cfDout(cfDout), .cfDoutEn(cfDoutEn),
    .busy(busy), .done(done), .rdData(rdData)
  );

  function automatic int tickOf(input logic [1:0] code);
    case (code)
      2'd0: return 4;
      2'd1: return 1;
      2'd2: return 2;
      default: return 8;
    endcase
  endfunction

  function automatic int phaseLen(input logic [FIELD_W-1:0] f);
    return (int'(f) + 1) * tickOf(cfgMult);
  endfunction

  function automatic int strobeLen(input bit wr, input int readyAfter);
    int base;
    base = phaseLen(wr ? tWe : tOe);
    if (!cfgWaitMode) return base;
    return ((base > readyAfter) ? base : readyAfter) + phaseLen(tWait);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic runTxn(input bit wr, input bit wide, input logic [ADDR_W-1:0] addr,
                        input logic [DATA_W-1:0] wdata, input logic [DATA_W-1:0] din,
                        input int readyAfter, input bit midReq);
    int busyC, leadC, ceC, oeC, weC, doneC, addrBad, doutBad, n;
    bit seenDone, prevOeLow;
    logic [DATA_W-1:0] expDout, expRd;
    busyC = 0; leadC = 0; ceC = 0; oeC = 0; weC = 0; doneC = 0;
    addrBad = 0; doutBad = 0; seenDone = 0; prevOeLow = 0;
    expDout = wide ? wdata : {8'h00, wdata[7:0]};
    expRd   = wide ? din : {8'h00, din[7:0]};
    @(negedge clk);
    reqWrite = wr; reqWide = wide; reqAddr = addr; reqWdata = wdata;
    cfDin = din; cfReady = 1'b0; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    for (n = 0; n < 3000 && !seenDone; n++) begin
      if (busy) busyC++;
      if (busy && cfCeN && ceC == 0) leadC++;
      if (!cfCeN) begin
        ceC++;
        if (cfAddr != addr) addrBad++;
      end
      if (!cfOeN) oeC++;
      if (!cfWeN) begin
        weC++;
        if (!cfDoutEn || cfDout != expDout) doutBad++;
      end
      if (cfOeN && prevOeLow) cfDin = ~din;
      prevOeLow = !cfOeN;
      if (cfgWaitMode && ((wr ? weC : oeC) == readyAfter)) cfReady = 1'b1;
      if (midReq && n == 2) begin reqValid = 1'b1; reqWrite = !wr; end
      if (midReq && n == 3) begin reqValid = 1'b0; reqWrite = wr; end
      if (done) begin
        doneC++;
        seenDone = 1;
      end else begin
        @(negedge clk);
      end
    end
    @(negedge clk);
    if (done) doneC++;
    check(seenDone, "R4 done seen", seenDone, 1);
    check(doneC == 1, "R4 done one clock", doneC, 1);
    check(leadC == phaseLen(tAdr), "R3 address lead", leadC, phaseLen(tAdr));
    check(ceC == phaseLen(tCe) + strobeLen(wr, readyAfter) +
                 phaseLen(wr ? tWrHold : tRdHold), "R3 R6 chip-enable span", ceC,
          phaseLen(tCe) + strobeLen(wr, readyAfter) + phaseLen(wr ? tWrHold : tRdHold));
    check(busyC == phaseLen(tAdr) + phaseLen(tCe) + strobeLen(wr, readyAfter) +
                   phaseLen(wr ? tWrHold : tRdHold) + phaseLen(tPause),
          "R2 R4 busy span", busyC, phaseLen(tAdr) + phaseLen(tCe) +
          strobeLen(wr, readyAfter) + phaseLen(wr ? tWrHold : tRdHold) + phaseLen(tPause));
    if (wr) begin
      check(weC == strobeLen(wr, readyAfter), "R5 R6 R7 write strobe", weC,
            strobeLen(wr, readyAfter));
      check(oeC == 0, "R5 R11 no read strobe on write", oeC, 0);
      check(doutBad == 0, "R9 R12 write data", doutBad, 0);
    end else begin
      check(oeC == strobeLen(wr, readyAfter), "R5 R6 R7 read strobe", oeC,
            strobeLen(wr, readyAfter));
      check(weC == 0, "R5 R11 no write strobe on read", weC, 0);
      check(rdData == expRd, "R8 R9 read data", int'(rdData), int'(expRd));
    end
    check(addrBad == 0, "R12 address", addrBad, 0);
  endtask

  task automatic setFields(input logic [1:0] m, input int a, input int c, input int o,
                           input int w, input int wt, input int rh, input int wh,
                           input int p, input bit wm);
    cfgMult = m; cfgWaitMode = wm;
    tAdr = FIELD_W'(a); tCe = FIELD_W'(c); tOe = FIELD_W'(o); tWe = FIELD_W'(w);
    tWait = FIELD_W'(wt); tRdHold = FIELD_W'(rh); tWrHold = FIELD_W'(wh);
    tPause = FIELD_W'(p);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seedVal;
    seedVal = $urandom(32'h5eed);
    repeat (3) @(negedge clk);
    // R1: outputs idle during reset
    check(cfCeN && cfOeN && cfWeN && !cfDoutEn && !busy && !done,
          "R1 reset state", {cfCeN, cfOeN, cfWeN, cfDoutEn, busy, done}, 6'b111000);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(cfCeN && cfOeN && cfWeN && !busy && !done, "R1 idle after reset",
          {cfCeN, cfOeN, cfWeN, busy, done}, 5'b11100);

    // R2: every prescaler code with fixed fields
    for (int m = 0; m < 4; m++) begin
      setFields(2'(m), 1, 2, 3, 1, 0, 1, 2, 1, 0);
      runTxn(1'b0, 1'b1, 8'h12, 16'h0, 16'hA55A, 1, 1'b0);
      runTxn(1'b1, 1'b1, 8'h34, 16'hBEEF, 16'h0, 1, 1'b0);
    end
    // R6: long stretch past strobe count, and short stretch
    setFields(2'd1, 0, 1, 2, 2, 3, 0, 1, 0, 1);
    runTxn(1'b0, 1'b1, 8'h01, 16'h0, 16'h1234, 15, 1'b0);
    runTxn(1'b1, 1'b1, 8'h02, 16'h5678, 16'h0, 9, 1'b0);
    runTxn(1'b0, 1'b1, 8'h03, 16'h0, 16'h9ABC, 1, 1'b0);
    // R7: wait mode off, ready held low throughout
    setFields(2'd2, 0, 0, 2, 2, 5, 0, 0, 0, 0);
    runTxn(1'b0, 1'b1, 8'h04, 16'h0, 16'hCAFE, 1, 1'b0);
    // R9: byte cycles
    setFields(2'd1, 0, 0, 1, 1, 0, 0, 0, 0, 0);
    runTxn(1'b0, 1'b0, 8'h05, 16'h0, 16'hFF3C, 1, 1'b0);
    runTxn(1'b1, 1'b0, 8'h06, 16'hEE5A, 16'h0, 1, 1'b0);
    // R11: request during a running cycle
    runTxn(1'b0, 1'b1, 8'h07, 16'h0, 16'h7777, 1, 1'b1);
    runTxn(1'b1, 1'b1, 8'h08, 16'h1111, 16'h0, 1, 1'b1);

    // R10: disabled region
    begin
      int act;
      act = 0;
      cfgEnable = 1'b0;
      @(negedge clk);
      reqWrite = 1'b1; reqValid = 1'b1;
      @(negedge clk);
      reqValid = 1'b0;
      for (int k = 0; k < 30; k++) begin
        if (busy || done || !cfCeN || !cfWeN || !cfOeN || cfDoutEn) act++;
        @(negedge clk);
      end
      check(act == 0, "R10 disabled region ignored", act, 0);
      cfgEnable = 1'b1;
    end

    // random cycles
    for (int i = 0; i < 40; i++) begin
      setFields(2'($urandom_range(0, 3)), $urandom_range(0, 3), $urandom_range(0, 3),
                $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3),
                $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3),
                1'($urandom_range(0, 1)));
      runTxn(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
             8'($urandom), 16'($urandom), 16'($urandom),
             $urandom_range(1, 40), 1'($urandom_range(0, 1)));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule